// File: doc/BRIEF.md
# Mixed-Width Integer Element Unit

This unit computes one element of an integer operation whose two sources and destination each carry their own element width of 8, 16, 32 or 64 bits. It supports add, shift left, logical shift right, arithmetic shift right, and the high half of a multiply in signed, unsigned and signed-by-unsigned forms. Each source is reduced to its own width and then extended to the working width. The working width is always the wider of the two source widths. The result is formed at that width, then fitted to the destination width by truncation or extension. Last, it is either left as a packed vector element with zeroed upper bits or widened to a full 64-bit scalar register value.

The datapath is combinational and is followed by a single output register. The input and output streams both use valid/ready. The input is accepted when `in_valid` and `in_ready` are high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged. Each accepted request appears on the output in the cycle after acceptance. A request that is not accepted does not alter the unit.

Top module: `elw_alu`

## Requirements
- R1: Width codes are 0=8, 1=16, 2=32, 3=64 bits. The working width OW is the larger of the two source widths. Only the low bits of each source that fit its own width are used, so higher input bits have no effect.
- R2: Source A is sign-extended from its width for codes 3 (arithmetic shift right), 4 (signed multiply-high) and 6 (signed-by-unsigned multiply-high), and zero-extended otherwise. Source B is sign-extended only for codes 3 and 4.
- R3: Code 0 (add) yields the sum of the extended sources modulo 2^OW.
- R4: Code 1 (shift left) shifts A left by the low bits of the extended B masked with OW-1, keeping OW bits. For example, a 16-bit and an 8-bit source give a mask of 15.
- R5: Code 2 (logical right) and code 3 (arithmetic right) shift by the same masked amount within OW bits.
- R6: Codes 4, 5 and 6 form the full product of the extended sources, shift it right by OW, and keep OW bits. Code 4 is signed by signed, code 5 is unsigned by unsigned, and code 6 is signed A by unsigned B.
- R7: When the destination width DW is at most OW, the OW-bit result is truncated to DW bits after the operation.
- R8: When DW exceeds OW, the result is extended from OW to DW: sign extension for codes 3, 4 and 6, zero extension otherwise. For a vector destination (`in_scalar`=0), output bits at and above DW are zero.
- R9: For a scalar destination (`in_scalar`=1), the DW-bit value is extended to 64 bits, using the same signedness as in R8.
- R10: `in_ready` is high exactly when the output register is empty or `out_ready` is high. An accepted request appears on `out_valid`/`out_data` in the next cycle. A result is held stable while `out_ready` is low.
- R11: Reset, active low, empties the output register, so `out_valid` is low, even if a result was pending.
- R12: Operation code 7 behaves as add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request may be taken this cycle |
| in_a | input | 64 | Source A (first operand / value to shift) |
| in_b | input | 64 | Source B (second operand / shift amount) |
| in_wa | input | 2 | Width code of source A |
| in_wb | input | 2 | Width code of source B |
| in_wd | input | 2 | Width code of destination |
| in_scalar | input | 1 | 1 = widen result to a full scalar register |
| in_op | input | 3 | Operation code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Fitted result |

## Verification
The assertions assume the consumer may hold `out_ready` low for any number of cycles, and that the producer's request fields are meaningful whenever `in_valid` is high. The shift checks look only at accepted requests. Random stimulus toggles both valid and ready independently, so stalls, back-to-back acceptance and simultaneous drain-and-fill all occur. It fills every input bit, including bits above each source's width, and draws all eight operation codes and every width combination. Directed requests pin down sign boundaries, shift masks, product alignment and each fitting case.

// File: rtl/elw_pkg.sv
package elw_pkg;
  localparam int WCODE_W = 2;
  localparam int NUM_WIDTHS = 1 << WCODE_W;

  typedef logic [WCODE_W-1:0] wcode_t;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SLL    = 3'd1,
    OP_SRL    = 3'd2,
    OP_SRA    = 3'd3,
    OP_MULH   = 3'd4,
    OP_MULHU  = 3'd5,
    OP_MULHSU = 3'd6,
    OP_ADD2   = 3'd7
  } elw_op_e;

  function automatic int unsigned code_bits(wcode_t c);
    return 32'd8 << c;
  endfunction

  function automatic logic a_signed(elw_op_e op);
    return (op == OP_SRA) || (op == OP_MULH) || (op == OP_MULHSU);
  endfunction

  function automatic logic b_signed(elw_op_e op);
    return (op == OP_SRA) || (op == OP_MULH);
  endfunction

  function automatic logic res_signed(elw_op_e op);
    return (op == OP_SRA) || (op == OP_MULH) || (op == OP_MULHSU);
  endfunction
endpackage

// File: rtl/elw_src_ext.sv
module elw_src_ext
  import elw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val,
  input  wcode_t          wcode,
  input  logic            sgn,
  output logic [XLEN-1:0] ext
);
  logic [XLEN-1:0] cand [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_w
    localparam int W = 8 << g;
    if (W >= XLEN) begin : g_full
      assign cand[g] = val;
    end else begin : g_part
      assign cand[g] = {{(XLEN-W){sgn & val[W-1]}}, val[W-1:0]};
    end
  end

  assign ext = cand[wcode];
endmodule

// File: rtl/elw_core.sv
module elw_core
  import elw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_en,
  input  logic [XLEN-1:0] ea,
  input  logic [XLEN-1:0] eb,
  input  wcode_t          opw,
  input  elw_op_e         op,
  output logic [XLEN-1:0] res
);
  localparam int SHW  = $clog2(XLEN);
  localparam int PW   = 2 * XLEN + 2;

  int unsigned         ow_bits;
  logic [SHW-1:0]      sh;
  logic [XLEN-1:0]     ow_mask;
  logic [XLEN-1:0]     raw;
  logic signed [XLEN:0] pa, pb;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] prod_sh;

  assign ow_bits = code_bits(opw);
  assign ow_mask = {XLEN{1'b1}} >> (XLEN - ow_bits);
  assign sh      = eb[SHW-1:0] & SHW'(ow_bits - 1);

  // Operand top bit carries the source signedness into the product
  assign pa = {a_signed(op) & ea[XLEN-1], ea};
  assign pb = {b_signed(op) & eb[XLEN-1], eb};

  always_comb begin
    prod    = PW'(pa) * PW'(pb);
    prod_sh = prod >>> ow_bits;
  end

  always_comb begin
    unique case (op)
      OP_SLL:                      raw = ea << sh;
      OP_SRL:                      raw = ea >> sh;
      OP_SRA:                      raw = $unsigned($signed(ea) >>> sh);
      OP_MULH, OP_MULHU, OP_MULHSU: raw = prod_sh[XLEN-1:0];
      default:                     raw = ea + eb;
    endcase
  end

  assign res = raw & ow_mask;

  // R4: bits shifted in from the right are zero
  p_sll_low_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && op == OP_SLL |-> (res & ~({XLEN{1'b1}} << sh)) == '0);

  // R5: logical right shift fills zeros from the top of the working width
  p_srl_top_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && op == OP_SRL && sh != '0 |-> (res >> (ow_bits - sh)) == '0);

  // R1: nothing above the working width survives the operation
  p_ow_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && opw != wcode_t'(NUM_WIDTHS-1) |-> (res >> ow_bits) == '0);
endmodule

// File: rtl/elw_dst_fit.sv
module elw_dst_fit
  import elw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] res_ow,
  input  wcode_t          opw,
  input  wcode_t          dw,
  input  logic            sgn,
  input  logic            scalar,
  output logic [XLEN-1:0] fitted
);
  int unsigned     ow_bits, dw_bits;
  logic [XLEN-1:0] ow_mask, dw_mask, mid;
  logic            ow_msb, dw_msb;

  assign ow_bits = code_bits(opw);
  assign dw_bits = code_bits(dw);
  assign ow_mask = {XLEN{1'b1}} >> (XLEN - ow_bits);
  assign dw_mask = {XLEN{1'b1}} >> (XLEN - dw_bits);
  assign ow_msb  = res_ow[ow_bits-1];

  always_comb begin
    if (dw_bits <= ow_bits)
      mid = res_ow & dw_mask;
    else
      mid = res_ow | ((sgn & ow_msb) ? (dw_mask & ~ow_mask) : '0);
  end

  assign dw_msb = mid[dw_bits-1];
  assign fitted = (scalar && sgn && dw_msb) ? (mid | ~dw_mask) : mid;
endmodule

// File: rtl/elw_alu.sv
module elw_alu
  import elw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [1:0]      in_wa,
  input  logic [1:0]      in_wb,
  input  logic [1:0]      in_wd,
  input  logic            in_scalar,
  input  logic [2:0]      in_op,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data
);
  elw_op_e         op;
  wcode_t          opw;
  logic [XLEN-1:0] ea, eb, res_ow, fitted;
  logic            take;
  logic            scl_q;
  wcode_t          dw_q;

  assign op   = elw_op_e'(in_op);
  assign opw  = (in_wa > in_wb) ? in_wa : in_wb;
  assign in_ready = !out_valid || out_ready;
  assign take = in_valid && in_ready;

  elw_src_ext #(.XLEN(XLEN)) u_ext_a (
    .val(in_a), .wcode(in_wa), .sgn(a_signed(op)), .ext(ea));
  elw_src_ext #(.XLEN(XLEN)) u_ext_b (
    .val(in_b), .wcode(in_wb), .sgn(b_signed(op)), .ext(eb));

  elw_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst_n(rst_n), .chk_en(take),
    .ea(ea), .eb(eb), .opw(opw), .op(op), .res(res_ow));

  elw_dst_fit #(.XLEN(XLEN)) u_fit (
    .res_ow(res_ow), .opw(opw), .dw(in_wd), .sgn(res_signed(op)),
    .scalar(in_scalar), .fitted(fitted));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= fitted;
      scl_q    <= in_scalar;
      dw_q     <= in_wd;
    end
  end

  // R10: an accepted request is presented next cycle
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10: a stalled result does not move
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10: an empty output register never refuses input
  p_empty_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8: packed vector elements carry nothing above their width
  p_vec_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !scl_q && dw_q != wcode_t'(NUM_WIDTHS-1)
      |-> (out_data >> code_bits(dw_q)) == '0);
endmodule

// File: tb/tb_elw_alu.sv
`timescale 1ns/1ps
module tb_elw_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [1:0]  in_wa = '0, in_wb = '0, in_wd = '0;
  logic        in_scalar = 1'b0;
  logic [2:0]  in_op = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [63:0] out_data;

  int total = 0, bad = 0;
  logic [63:0] q_val[$];
  int          q_op[$];

  always #2.5 clk = ~clk;

  elw_alu dut (.*);

  function automatic logic [127:0] m128(int n);
    return (n >= 128) ? {128{1'b1}} : ((128'h1 << n) - 128'h1);
  endfunction

  function automatic logic [63:0] ref_calc(logic [63:0] a, logic [63:0] b,
      logic [1:0] wa, logic [1:0] wb, logic [1:0] wd, logic scl, logic [2:0] op);
    int wab = 8 << wa, wbb = 8 << wb, dw = 8 << wd;
    int ow = (wab > wbb) ? wab : wbb;
    bit sa = (op == 3 || op == 4 || op == 6);
    bit sb = (op == 3 || op == 4);
    logic [127:0] xa, xb, r, e;
    int sh;
    xa = {64'h0, a} & m128(wab);
    if (sa && a[wab-1]) xa = xa | ~m128(wab);
    xb = {64'h0, b} & m128(wbb);
    if (sb && b[wbb-1]) xb = xb | ~m128(wbb);
    sh = int'(xb[6:0]) & (ow - 1);
    case (op)
      3'd1: r = xa << sh;
      3'd2: r = (xa & m128(ow)) >> sh;
      3'd3: r = $unsigned($signed(xa) >>> sh);
      3'd4, 3'd5, 3'd6: r = (xa * xb) >> ow;
      default: r = xa + xb;
    endcase
    r = r & m128(ow);
    if (dw <= ow) e = r & m128(dw);
    else e = r | ((sa && r[ow-1]) ? (m128(dw) & ~m128(ow)) : 128'h0);
    if (scl && sa && e[dw-1]) e = e | ~m128(dw);
    return e[63:0];
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 7: return "R3/R12 add";
      1: return "R4 sll";
      2, 3: return "R5 shift right";
      default: return "R6 mulh";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic dir1(string tag, logic [63:0] a, logic [63:0] b, logic [1:0] wa,
      logic [1:0] wb, logic [1:0] wd, logic scl, logic [2:0] op);
    logic [63:0] e = ref_calc(a, b, wa, wb, wd, scl, op);
    @(negedge clk);
    in_a = a; in_b = b; in_wa = wa; in_wb = wb; in_wd = wd;
    in_scalar = scl; in_op = op; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && out_data === e, tag, out_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11 reset empty", {63'h0, out_valid}, 64'h0);
    rst_n = 1'b1;

    // R11: reset drops a pending result
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_a = 64'h5; in_b = 64'h6;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R10 stalled result present", {63'h0, out_valid}, 64'h1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 reset clears pending", {63'h0, out_valid}, 64'h0);
    rst_n = 1'b1; out_ready = 1'b1;

    dir1("R1 widths and ignored upper bits", 64'hDEAD_0000_1234_00FF, 64'h7777_AB01, 2'd1, 2'd0, 2'd1, 1'b0, 3'd0);
    dir1("R2 signed-by-unsigned extension", 64'hFFFF_FF80, 64'h0000_00FF, 2'd0, 2'd0, 2'd0, 1'b0, 3'd6);
    dir1("R3 add wraps at 64", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 2'd3, 2'd3, 1'b0, 3'd0);
    dir1("R4 sll mask 15", 64'h0001, 64'h0013, 2'd1, 2'd0, 2'd3, 1'b0, 3'd1);
    dir1("R5 sra 8-bit", 64'h80, 64'h0F, 2'd0, 2'd0, 2'd0, 1'b0, 3'd3);
    dir1("R5 srl mask 31", 64'h8000_0000, 64'h21, 2'd2, 2'd0, 2'd2, 1'b0, 3'd2);
    dir1("R6 mulh 32x8", 64'h8000_0000, 64'h02, 2'd2, 2'd0, 2'd3, 1'b0, 3'd4);
    dir1("R6 mulhu 16x8", 64'hFFFF, 64'hFF, 2'd1, 2'd0, 2'd1, 1'b0, 3'd5);
    dir1("R7 truncate after add", 64'h1FF, 64'h1, 2'd3, 2'd3, 2'd0, 1'b0, 3'd0);
    dir1("R8 sign extend to 32 vector", 64'h80, 64'h0, 2'd0, 2'd0, 2'd2, 1'b0, 3'd3);
    dir1("R8 zero extend add", 64'hF0, 64'h20, 2'd0, 2'd0, 2'd2, 1'b0, 3'd0);
    dir1("R9 scalar sign extend", 64'h80, 64'h0, 2'd0, 2'd0, 2'd1, 1'b1, 3'd3);
    dir1("R9 scalar from narrow dest", 64'hFFFF_8123, 64'h0, 2'd1, 2'd1, 2'd0, 1'b1, 3'd3);
    dir1("R12 code 7 adds", 64'h5, 64'h6, 2'd0, 2'd0, 2'd0, 1'b0, 3'd7);

    @(negedge clk);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic exp_rdy;
      if (cyc != 0) @(negedge clk);
      if (q_val.size() > 0)
        chk(out_valid === 1'b1 && out_data === q_val[0], tag_of(q_op[0]), out_data, q_val[0]);
      else
        chk(out_valid === 1'b0, "R10 idle output", {63'h0, out_valid}, 64'h0);
      out_ready = ($urandom_range(0, 3) != 0);
      in_valid  = ($urandom_range(0, 2) != 0);
      in_a = {$urandom, $urandom};
      in_b = ($urandom_range(0, 3) == 0) ? 64'($urandom_range(0, 80)) : {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) in_a = 64'h8000_0000_0000_0000 >> (8 * $urandom_range(0, 7));
      in_wa = 2'($urandom); in_wb = 2'($urandom); in_wd = 2'($urandom);
      in_scalar = 1'($urandom); in_op = 3'($urandom);
      #1;
      exp_rdy = (q_val.size() == 0) || out_ready;
      chk(in_ready === exp_rdy, "R10 ready rule", {63'h0, in_ready}, {63'h0, exp_rdy});
      if (out_valid && out_ready) begin
        void'(q_val.pop_front());
        void'(q_op.pop_front());
      end
      if (in_valid && in_ready) begin
        q_val.push_back(ref_calc(in_a, in_b, in_wa, in_wb, in_wd, in_scalar, in_op));
        q_op.push_back(int'(in_op));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule